// File: doc/BRIEF.md
# Machine-Check Response Controller

This block decides what a processor core does when the memory system reports a machine-check condition. There are three error sources: an access to an address that does not exist, a data error, and a storage-protection violation reported by the chip-select logic. Any of these in a clock cycle counts as one machine-check event. The block then chooses one of three outcomes. It can trap to the machine-check handler, enter a sticky checkstop state, or ask the debug unit to take over.

The choice depends on four things: the machine-check enable bit of the machine state register, a debug-enabled strap, a checkstop debug-enable bit and a machine-check debug-enable bit. The block also has a vector-base strap that selects the low or the high exception area. Both straps are latched while reset is held. When the block enters checkstop, it raises a reset request toward the system interface unit. That request stays high until the core is reset. The handler address, the causes of the last event, and the checkstop flag are all outputs.

Top module: `mchk_responder`

## Requirements
- R1: In a cycle with no checkstop active, any non-zero error input produces exactly one of `take_exc`, `enter_chkstop` or `enter_debug`. That pulse is high for one cycle, in the cycle after the clock edge that samples the inputs. This holds even when several causes are asserted together. In a cycle with no error input, none of the three pulses is produced in the next cycle.
- R2: With the latched debug strap at 0, the outcome depends only on `msr_me`. `msr_me`=0 gives checkstop and `msr_me`=1 gives a trap. `der_chkstop_en` and `der_mchk_en` have no effect.
- R3: With the latched debug strap at 1 and `msr_me`=0, the outcome depends on `der_chkstop_en`. A value of 0 gives checkstop and a value of 1 gives debug entry. `der_mchk_en` has no effect.
- R4: With the latched debug strap at 1 and `msr_me`=1, the outcome depends on `der_mchk_en`. A value of 0 gives a trap and a value of 1 gives debug entry. `der_chkstop_en` has no effect.
- R5: `vector_addr` is 32'h0000_0200 when the latched vector-base strap is 0 and 32'hFFF0_0200 when it is 1. It carries this value only in the cycle `take_exc` is high and is 0 in every other cycle.
- R6: `chkstop_active` and `sys_reset_req` rise together with the `enter_chkstop` pulse. They then stay high until `rst_n` is asserted.
- R7: While `chkstop_active` is high, error inputs produce no pulse and leave `cause` unchanged.
- R8: `cause` holds the error inputs sampled at the last accepted event: bit 0 for non-existent address, bit 1 for data error, bit 2 for protection violation.
- R9: `dbg_en_cfg` and `ip_cfg` are sampled only on clock edges while `rst_n` is low. Later changes to them have no effect until the next reset.
- R10: While `rst_n` is low, all pulses, `chkstop_active`, `sys_reset_req`, `cause` and `vector_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_noaddr | input | 1 | Access to a non-existent address |
| err_data | input | 1 | Data error detected |
| err_prot | input | 1 | Storage-protection violation from chip-select logic |
| msr_me | input | 1 | Machine-check enable from the machine state register |
| dbg_en_cfg | input | 1 | Debug-enabled strap, latched during reset |
| der_chkstop_en | input | 1 | Debug enable for checkstop conditions |
| der_mchk_en | input | 1 | Debug enable for machine-check traps |
| ip_cfg | input | 1 | Vector-base strap, latched during reset |
| take_exc | output | 1 | One-cycle pulse: trap to the handler |
| enter_chkstop | output | 1 | One-cycle pulse: checkstop entered |
| enter_debug | output | 1 | One-cycle pulse: debug entry requested |
| vector_addr | output | 32 | Handler address, valid with `take_exc` |
| chkstop_active | output | 1 | Sticky checkstop state |
| sys_reset_req | output | 1 | Reset request to the system interface unit |
| cause | output | 3 | Causes of the last accepted event |

## Verification
Two behaviours are the hardest to reach from the ports. The first is that inputs are ignored after the decision is fixed: errors while in checkstop, and strap changes after reset. To reach it, the stimulus first drives the block into checkstop through each of the two checkstop paths, then sends further error patterns and watches that the pulses stay quiet and `cause` holds. The second needs a reset with straps that differ from the values driven afterwards. The outcome and vector that follow must then match the latched straps and not the live pins.

// File: rtl/mchk_pkg.sv
package mchk_pkg;

  localparam int unsigned CAUSE_W = 3;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_TRAP  = 2'd1,
    ACT_HALT  = 2'd2,
    ACT_DEBUG = 2'd3
  } mchk_act_e;

endpackage

// File: rtl/mchk_strap_latch.sv
module mchk_strap_latch #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] strap_in,
  output logic [W-1:0] strap_q
);

  // each bit loads only while reset is held; enable is the reset level
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bit_q;
    logic bit_d;
    logic load_en;

    always_comb begin
      load_en = !rst_n;
      bit_d   = load_en ? strap_in[i] : bit_q;
    end

    always_ff @(posedge clk) begin
      bit_q <= bit_d;
    end

    assign strap_q[i] = bit_q;
  end

endmodule

// File: rtl/mchk_action_sel.sv
module mchk_action_sel
  import mchk_pkg::*;
(
  input  logic      dbg_on,
  input  logic      me,
  input  logic      chkstop_en,
  input  logic      mchk_en,
  output mchk_act_e act
);

  always_comb begin
    if (!dbg_on) begin
      act = me ? ACT_TRAP : ACT_HALT;
    end else if (!me) begin
      act = chkstop_en ? ACT_DEBUG : ACT_HALT;
    end else begin
      act = mchk_en ? ACT_DEBUG : ACT_TRAP;
    end
  end

endmodule

// File: rtl/mchk_event_reg.sv
module mchk_event_reg
  import mchk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  mchk_act_e          act,
  input  logic [CAUSE_W-1:0] causes_in,
  output logic               pulse_trap,
  output logic               pulse_halt,
  output logic               pulse_debug,
  output logic [CAUSE_W-1:0] cause_q
);

  logic               trap_d, halt_d, debug_d;
  logic [CAUSE_W-1:0] cause_d;

  always_comb begin
    trap_d  = accept && (act == ACT_TRAP);
    halt_d  = accept && (act == ACT_HALT);
    debug_d = accept && (act == ACT_DEBUG);
    cause_d = accept ? causes_in : cause_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_trap  <= 1'b0;
      pulse_halt  <= 1'b0;
      pulse_debug <= 1'b0;
      cause_q     <= '0;
    end else begin
      pulse_trap  <= trap_d;
      pulse_halt  <= halt_d;
      pulse_debug <= debug_d;
      cause_q     <= cause_d;
    end
  end

endmodule

// File: rtl/mchk_halt_state.sv
module mchk_halt_state (
  input  logic clk,
  input  logic rst_n,
  input  logic set_en,
  output logic halted
);

  logic halted_d;

  always_comb begin
    halted_d = halted || set_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted <= 1'b0;
    end else begin
      halted <= halted_d;
    end
  end

endmodule

// File: rtl/mchk_responder.sv
module mchk_responder
  import mchk_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] BASE_LO    = 32'h0000_0000,
  parameter logic [ADDR_W-1:0] BASE_HI    = 32'hFFF0_0000,
  parameter logic [ADDR_W-1:0] VEC_OFFSET = 32'h0000_0200
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               err_noaddr,
  input  logic               err_data,
  input  logic               err_prot,
  input  logic               msr_me,
  input  logic               dbg_en_cfg,
  input  logic               der_chkstop_en,
  input  logic               der_mchk_en,
  input  logic               ip_cfg,
  output logic               take_exc,
  output logic               enter_chkstop,
  output logic               enter_debug,
  output logic [ADDR_W-1:0]  vector_addr,
  output logic               chkstop_active,
  output logic               sys_reset_req,
  output logic [CAUSE_W-1:0] cause
);

  localparam int unsigned STRAP_W = 2;
  localparam logic [ADDR_W-1:0] VEC_LO = BASE_LO | VEC_OFFSET;
  localparam logic [ADDR_W-1:0] VEC_HI = BASE_HI | VEC_OFFSET;

  logic [STRAP_W-1:0] strap_q;
  logic               dbg_on_q;
  logic               ip_q;
  logic [CAUSE_W-1:0] err_vec;
  logic               accept;
  logic               halted;
  mchk_act_e          act;

  assign err_vec = {err_prot, err_data, err_noaddr};

  mchk_strap_latch #(.W(STRAP_W)) u_straps (
    .clk      (clk),
    .rst_n    (rst_n),
    .strap_in ({ip_cfg, dbg_en_cfg}),
    .strap_q  (strap_q)
  );

  assign dbg_on_q = strap_q[0];
  assign ip_q     = strap_q[1];

  mchk_action_sel u_sel (
    .dbg_on     (dbg_on_q),
    .me         (msr_me),
    .chkstop_en (der_chkstop_en),
    .mchk_en    (der_mchk_en),
    .act        (act)
  );

  // an event is accepted only when a cause is present and the core runs
  assign accept = (|err_vec) && !halted;

  mchk_event_reg u_evt (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .act         (act),
    .causes_in   (err_vec),
    .pulse_trap  (take_exc),
    .pulse_halt  (enter_chkstop),
    .pulse_debug (enter_debug),
    .cause_q     (cause)
  );

  mchk_halt_state u_halt (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (accept && (act == ACT_HALT)),
    .halted (halted)
  );

  assign chkstop_active = halted;
  assign sys_reset_req  = halted;
  assign vector_addr    = take_exc ? (ip_q ? VEC_HI : VEC_LO) : '0;

endmodule

// File: rtl/mchk_responder_chk.sv
module mchk_responder_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              err_noaddr,
  input logic              err_data,
  input logic              err_prot,
  input logic              take_exc,
  input logic              enter_chkstop,
  input logic              enter_debug,
  input logic [ADDR_W-1:0] vector_addr,
  input logic              chkstop_active,
  input logic              sys_reset_req,
  input logic [2:0]        cause
);

  logic any_err;
  assign any_err = err_noaddr || err_data || err_prot;

  assert_pulse_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_exc, enter_chkstop, enter_debug}));

  assert_event_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (any_err && !chkstop_active) |=>
      ($countones({take_exc, enter_chkstop, enter_debug}) == 1));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !any_err |=> !(take_exc || enter_chkstop || enter_debug));

  assert_vector_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |-> (vector_addr == 32'h0000_0200 || vector_addr == 32'hFFF0_0200));

  assert_vector_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !take_exc |-> (vector_addr == '0));

  assert_halt_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chkstop_active |=> chkstop_active);

  assert_halt_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chkstop_active) |-> enter_chkstop);

  assert_reset_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req == chkstop_active);

  assert_halt_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chkstop_active |=> !(take_exc || enter_chkstop || enter_debug));

  assert_halt_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chkstop_active |=> $stable(cause));

  assert_cause_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (any_err && !chkstop_active) |=>
      (cause == $past({err_prot, err_data, err_noaddr})));

endmodule

bind mchk_responder mchk_responder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .err_noaddr     (err_noaddr),
  .err_data       (err_data),
  .err_prot       (err_prot),
  .take_exc       (take_exc),
  .enter_chkstop  (enter_chkstop),
  .enter_debug    (enter_debug),
  .vector_addr    (vector_addr),
  .chkstop_active (chkstop_active),
  .sys_reset_req  (sys_reset_req),
  .cause          (cause)
);

// File: tb/mchk_responder_test.sv
module mchk_responder_test;

  logic        clk;
  logic        rst_n;
  logic        err_noaddr, err_data, err_prot;
  logic        msr_me, dbg_en_cfg, der_chkstop_en, der_mchk_en, ip_cfg;
  logic        take_exc, enter_chkstop, enter_debug;
  logic [31:0] vector_addr;
  logic        chkstop_active, sys_reset_req;
  logic [2:0]  cause;

  typedef struct {
    logic        take;
    logic        halt;
    logic        dbg;
    logic [31:0] vec;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          checks = 0;
  int          errors = 0;
  bit          done   = 0;
  logic        m_halt;
  logic [2:0]  m_cause;
  logic        m_dbg, m_ip;

  mchk_responder uut (
    .clk(clk), .rst_n(rst_n),
    .err_noaddr(err_noaddr), .err_data(err_data), .err_prot(err_prot),
    .msr_me(msr_me), .dbg_en_cfg(dbg_en_cfg),
    .der_chkstop_en(der_chkstop_en), .der_mchk_en(der_mchk_en), .ip_cfg(ip_cfg),
    .take_exc(take_exc), .enter_chkstop(enter_chkstop), .enter_debug(enter_debug),
    .vector_addr(vector_addr), .chkstop_active(chkstop_active),
    .sys_reset_req(sys_reset_req), .cause(cause)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic compare(input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [39:0] pack_out();
    return {take_exc, enter_chkstop, enter_debug, chkstop_active, sys_reset_req,
            cause, vector_addr};
  endfunction

  // scoreboard monitor: samples 5 ns after each rising edge
  always begin
    @(posedge clk);
    #5;
    if (rst_n && !done) begin
      exp_t e;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
      end else begin
        e.take = 1'b0; e.halt = 1'b0; e.dbg = 1'b0; e.vec = '0;
        e.tag  = m_halt ? "R6" : "R1";
      end
      compare(e.tag, pack_out(),
              {e.take, e.halt, e.dbg, m_halt, m_halt, m_cause, e.vec});
    end
  end

  task automatic apply_reset(input logic dbg, input logic ip);
    @(negedge clk);
    rst_n = 1'b0;
    {err_prot, err_data, err_noaddr} = 3'b000;
    dbg_en_cfg = dbg;
    ip_cfg     = ip;
    repeat (3) @(negedge clk);
    compare("R10", pack_out(), 40'h0);
    rst_n  = 1'b1;
    m_halt = 1'b0; m_cause = 3'b000; m_dbg = dbg; m_ip = ip;
  endtask

  // driver: applies one error pattern and pushes the expected result
  task automatic fire(input logic [2:0] e, input logic me, input logic cse,
                      input logic mce, input string tag);
    exp_t x;
    @(negedge clk);
    {err_prot, err_data, err_noaddr} = e;
    msr_me = me; der_chkstop_en = cse; der_mchk_en = mce;
    x.take = 1'b0; x.halt = 1'b0; x.dbg = 1'b0; x.vec = '0; x.tag = tag;
    if (!m_halt && e != 3'b000) begin
      if (!m_dbg)   begin if (me) x.take = 1'b1; else x.halt = 1'b1; end
      else if (!me) begin if (cse) x.dbg = 1'b1; else x.halt = 1'b1; end
      else          begin if (mce) x.dbg = 1'b1; else x.take = 1'b1; end
      if (x.take) x.vec = m_ip ? 32'hFFF0_0200 : 32'h0000_0200;
      m_cause = e;
      if (x.halt) m_halt = 1'b1;
    end
    sb_q.push_back(x);
    @(negedge clk);
    {err_prot, err_data, err_noaddr} = 3'b000;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    {err_prot, err_data, err_noaddr} = 3'b000;
    msr_me = 0; der_chkstop_en = 0; der_mchk_en = 0; dbg_en_cfg = 0; ip_cfg = 0;
    m_halt = 0; m_cause = 0; m_dbg = 0; m_ip = 0;

    // debug off: only msr_me matters (R2), multi-cause capture (R8)
    apply_reset(1'b0, 1'b0);
    fire(3'b001, 1'b1, 1'b1, 1'b1, "R2");
    fire(3'b010, 1'b1, 1'b0, 1'b0, "R2");
    fire(3'b110, 1'b1, 1'b0, 1'b1, "R8");
    fire(3'b111, 1'b1, 1'b1, 1'b0, "R1");
    fire(3'b100, 1'b0, 1'b1, 1'b1, "R2");
    fire(3'b011, 1'b1, 1'b0, 1'b0, "R7");
    fire(3'b101, 1'b0, 1'b1, 1'b1, "R7");
    repeat (4) @(negedge clk);

    // debug on, high vector base (R3, R4, R5)
    apply_reset(1'b1, 1'b1);
    fire(3'b001, 1'b0, 1'b1, 1'b0, "R3");
    fire(3'b010, 1'b1, 1'b0, 1'b0, "R4");
    fire(3'b100, 1'b1, 1'b1, 1'b1, "R4");
    fire(3'b011, 1'b1, 1'b1, 1'b0, "R5");
    fire(3'b111, 1'b0, 1'b1, 1'b1, "R3");
    fire(3'b010, 1'b0, 1'b0, 1'b1, "R3");
    fire(3'b001, 1'b1, 1'b0, 1'b0, "R7");
    repeat (3) @(negedge clk);

    // straps changed after reset must not matter (R9)
    apply_reset(1'b0, 1'b1);
    dbg_en_cfg = 1'b1;
    ip_cfg     = 1'b0;
    fire(3'b001, 1'b1, 1'b1, 1'b1, "R9");
    fire(3'b100, 1'b0, 1'b1, 1'b1, "R9");
    fire(3'b010, 1'b1, 1'b0, 1'b1, "R7");
    repeat (3) @(negedge clk);

    // reset clears checkstop (R6)
    apply_reset(1'b0, 1'b0);
    fire(3'b001, 1'b1, 1'b0, 1'b0, "R6");
    repeat (3) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule